// File: doc/BRIEF.md
# Triggered pipeline charge integrator

This block serves one detector channel whose shaped analog pulse is digitized by a free-running ADC. Every clock the new sample is written into a circular delay line that is long enough to span the level-1 trigger latency. When no trigger comes, the oldest sample is overwritten and never looked at again.

When a trigger is accepted, the delayed sample stream is read back as it leaves the delay line. The first delayed sample is kept as the pedestal. The next window of samples, each minus that pedestal, is summed in a signed accumulator. The finished sum goes into a small per-channel output queue only if it is strictly greater than a programmable threshold. The sequencer accepts no new trigger until the window and its threshold decision are complete. Software writes the threshold through a single-cycle write port, and the write takes effect only while the sequencer is idle.

Top module: `charge_integ`

## Requirements
- R1: After reset, `out_valid` is 0, `ovf` is 0 and the threshold register holds 0.
- R2: Clock edges are numbered by the sample written at each edge. For a trigger accepted at edge t, the pedestal is the sample written at edge t-DEPTH-1. The window is the WIN_LEN samples written at edges t-DEPTH through t-DEPTH+WIN_LEN-1 (DEPTH=257, WIN_LEN=40 by default).
- R3: The result is the signed sum over the window of (sample - pedestal), in ACC_W two's-complement bits (17 by default). Sums below zero, down to -40920, and up to +40920, are reported without wrap.
- R4: A result is stored only if it is strictly greater than the signed threshold. A result equal to the threshold, or below it, is discarded.
- R5: A stored result is visible on `out_valid`/`out_sum` after edge t+WIN_LEN+1.
- R6: A trigger is accepted only when the sequencer is idle. Triggers at edges t+1 through t+WIN_LEN+1 are ignored and produce no output. A trigger at edge t+WIN_LEN+2 or later can be accepted.
- R7: A threshold write (`cfg_we` high at an edge) takes effect only when the sequencer is idle at that edge. A write that arrives during a window is ignored, and later results use the old value.
- R8: The output queue holds up to FIFO_DEPTH results (4 by default) in arrival order. The head entry is shown while `out_valid` is 1, and it is removed at an edge where both `out_valid` and `out_ready` are 1.
- R9: A result that passes the threshold while the queue already holds FIFO_DEPTH entries is dropped. `ovf` then goes to 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_in | input | SAMPLE_W | Unsigned ADC sample, one per clock |
| trig | input | 1 | Level-1 trigger, sampled each edge |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_thr | input | ACC_W | Signed threshold value to write |
| out_valid | output | 1 | Output queue holds at least one result |
| out_sum | output | ACC_W | Signed result at the head of the queue |
| out_ready | input | 1 | Consumer takes the head result |
| ovf | output | 1 | Sticky flag: a passing result was dropped because the queue was full |

## Verification
The hardest situation to reach from the ports is a window whose pedestal and window samples have known, extreme values. Those samples enter the pipeline 257 edges before the trigger that uses them. The stimulus therefore holds a constant pedestal level for longer than the pipeline, then switches to the window level. It fires the trigger exactly DEPTH edges after the switch, so that the pedestal is the last sample at the old level. The same placement is used for sums that equal the threshold, for the largest positive and negative sums, and for a threshold write that lands mid-window. Queue overflow is reached by holding `out_ready` low across five accepted triggers.

// File: rtl/tci_pkg.sv
package tci_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WIN  = 2'd1,
        ST_CHK  = 2'd2
    } seq_state_e;

    // Width needed for a signed sum of win terms, each a signed difference
    // of two unsigned sw-bit samples.
    function automatic int acc_width(input int sw, input int win);
        return sw + 1 + $clog2(win);
    endfunction

    // Pointer width for a memory or queue of the given depth.
    function automatic int ptr_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/tci_pipe.sv
module tci_pipe #(
    parameter int SAMPLE_W = 10,
    parameter int DEPTH    = 257
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] din,
    output logic [SAMPLE_W-1:0] dout
);
    localparam int AW = tci_pkg::ptr_width(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [SAMPLE_W-1:0] mem [DEPTH];
    logic [AW-1:0]       wr_ptr;

    // Read-before-write on the same cell: the read returns the sample
    // written DEPTH edges earlier, then the cell takes the new sample.
    always_ff @(posedge clk) begin
        dout        <= mem[wr_ptr];
        mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
        end else if (wr_ptr == LAST) begin
            wr_ptr <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(1);
        end
    end

endmodule

// File: rtl/tci_seq.sv
module tci_seq
    import tci_pkg::*;
#(
    parameter int SAMPLE_W = 10,
    parameter int WIN_LEN  = 40,
    parameter int ACC_W    = 17
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [SAMPLE_W-1:0]     rd_data,
    input  logic                    trig,
    input  logic                    cfg_we,
    input  logic signed [ACC_W-1:0] cfg_thr,
    output logic                    push,
    output logic signed [ACC_W-1:0] push_sum,
    output logic                    busy,
    output logic signed [ACC_W-1:0] thr_out
);
    localparam int CW = $clog2(WIN_LEN + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(WIN_LEN - 1);
    localparam int EXT = ACC_W - SAMPLE_W - 1;

    seq_state_e              state;
    logic [CW-1:0]           cnt;
    logic [SAMPLE_W-1:0]     base;
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] thr;
    logic signed [SAMPLE_W:0] diff;
    logic signed [ACC_W-1:0] diff_ext;

    always_comb begin
        diff     = $signed({1'b0, rd_data}) - $signed({1'b0, base});
        diff_ext = {{EXT{diff[SAMPLE_W]}}, diff};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            base  <= '0;
            acc   <= '0;
            thr   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (cfg_we) begin
                        thr <= cfg_thr;
                    end
                    if (trig) begin
                        base  <= rd_data;
                        acc   <= '0;
                        cnt   <= '0;
                        state <= ST_WIN;
                    end
                end
                ST_WIN: begin
                    acc <= acc + diff_ext;
                    if (cnt == CNT_LAST) begin
                        state <= ST_CHK;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_CHK: begin
                    state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        push     = (state == ST_CHK) && (acc > thr);
        push_sum = acc;
        busy     = (state != ST_IDLE);
        thr_out  = thr;
    end

endmodule

// File: rtl/tci_fifo.sv
module tci_fifo #(
    parameter int W     = 17,
    parameter int DEPTH = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           push,
    input  logic [W-1:0]                   din,
    input  logic                           pop,
    output logic [W-1:0]                   dout,
    output logic                           valid,
    output logic                           full,
    output logic [$clog2(DEPTH+1)-1:0]     cnt,
    output logic                           ovf
);
    localparam int PW = tci_pkg::ptr_width(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] PLAST = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp;
    logic [PW-1:0] rp;
    logic          do_push;
    logic          do_pop;

    always_comb begin
        full    = (cnt == CW'(DEPTH));
        valid   = (cnt != '0);
        do_push = push && !full;
        do_pop  = pop && valid;
        dout    = mem[rp];
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            if (do_push) begin
                wp <= (wp == PLAST) ? '0 : wp + PW'(1);
            end
            if (do_pop) begin
                rp <= (rp == PLAST) ? '0 : rp + PW'(1);
            end
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
            if (push && full) begin
                ovf <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/charge_integ.sv
module charge_integ #(
    parameter int SAMPLE_W   = 10,
    parameter int DEPTH      = 257,
    parameter int WIN_LEN    = 40,
    parameter int FIFO_DEPTH = 4,
    parameter int ACC_W      = tci_pkg::acc_width(SAMPLE_W, WIN_LEN)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] adc_in,
    input  logic                trig,
    input  logic                cfg_we,
    input  logic [ACC_W-1:0]    cfg_thr,
    output logic                out_valid,
    output logic [ACC_W-1:0]    out_sum,
    input  logic                out_ready,
    output logic                ovf
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    logic [SAMPLE_W-1:0]     pipe_q;
    logic                    seq_push;
    logic signed [ACC_W-1:0] seq_sum;
    logic                    seq_busy;
    logic signed [ACC_W-1:0] seq_thr;
    logic                    fifo_full;
    logic [CNT_W-1:0]        fifo_cnt;

    tci_pipe #(
        .SAMPLE_W (SAMPLE_W),
        .DEPTH    (DEPTH)
    ) u_pipe (
        .clk  (clk),
        .rst  (rst),
        .din  (adc_in),
        .dout (pipe_q)
    );

    tci_seq #(
        .SAMPLE_W (SAMPLE_W),
        .WIN_LEN  (WIN_LEN),
        .ACC_W    (ACC_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .rd_data  (pipe_q),
        .trig     (trig),
        .cfg_we   (cfg_we),
        .cfg_thr  ($signed(cfg_thr)),
        .push     (seq_push),
        .push_sum (seq_sum),
        .busy     (seq_busy),
        .thr_out  (seq_thr)
    );

    tci_fifo #(
        .W     (ACC_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (seq_push),
        .din   (seq_sum),
        .pop   (out_ready),
        .dout  (out_sum),
        .valid (out_valid),
        .full  (fifo_full),
        .cnt   (fifo_cnt),
        .ovf   (ovf)
    );

endmodule

// File: rtl/tci_chk.sv
module tci_chk #(
    parameter int ACC_W      = 17,
    parameter int FIFO_DEPTH = 4,
    parameter int CNT_W      = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic [ACC_W-1:0] thr,
    input logic             push,
    input logic             full,
    input logic [CNT_W-1:0] cnt,
    input logic             ovf,
    input logic             out_valid
);

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    // R9
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (push && full) |=> ovf);

    // R8
    fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(FIFO_DEPTH));

    // R7
    thr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(thr));

    // R5
    push_visible_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !full) |=> out_valid);

    // R6
    single_push_chk: assert property (@(posedge clk) disable iff (rst)
        push |=> !push);

endmodule

bind charge_integ tci_chk #(
    .ACC_W      (ACC_W),
    .FIFO_DEPTH (FIFO_DEPTH),
    .CNT_W      (CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (seq_busy),
    .thr       (seq_thr),
    .push      (seq_push),
    .full      (fifo_full),
    .cnt       (fifo_cnt),
    .ovf       (ovf),
    .out_valid (out_valid)
);

// File: tb/charge_integ_tb.sv
module charge_integ_tb;

    localparam int SW    = 10;
    localparam int DEPTH = 257;
    localparam int WIN   = 40;
    localparam int FD    = 4;
    localparam int AW    = 17;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [SW-1:0] adc_in = '0;
    logic          trig = 1'b0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_thr = '0;
    logic          out_valid;
    logic [AW-1:0] out_sum;
    logic          out_ready = 1'b0;
    logic          ovf;

    always #10 clk = ~clk;

    charge_integ u_dut (
        .clk       (clk),
        .rst       (rst),
        .adc_in    (adc_in),
        .trig      (trig),
        .cfg_we    (cfg_we),
        .cfg_thr   (cfg_thr),
        .out_valid (out_valid),
        .out_sum   (out_sum),
        .out_ready (out_ready),
        .ovf       (ovf)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // stimulus drivers
    int drv_s = 0;
    bit drv_trig = 0;
    bit drv_we = 0;
    int drv_thr = 0;
    bit drv_ready = 1;
    bit auto_gen = 0;
    int ped = 300;
    int amp = 0;
    string cur_tag = "R2";

    // model
    int e = 0;
    int hist [0:1023];
    int mthr = 0;
    int next_free = 0;
    int mcount = 0;
    bit movf = 0;
    bit pend = 0;
    int pend_edge = 0;
    int pend_val = 0;
    string pend_tag = "";
    int eq [0:255];
    string eq_tag [0:255];
    int head = 0;
    int tail = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at edge %0d", tag, act, exp, e);
        end
    endtask

    function automatic int gen_sample();
        int v;
        if (amp == 0 && $urandom_range(0, 49) == 0) begin
            amp = $urandom_range(50, 600);
        end
        v = ped + $urandom_range(0, 6) - 3 + amp;
        amp = (amp * 3) / 4;
        if (v < 0) v = 0;
        if (v > 1023) v = 1023;
        return v;
    endfunction

    function automatic int window_sum(input int t);
        int b;
        int s;
        b = hist[(t - DEPTH - 1) & 1023];
        s = 0;
        for (int k = 0; k < WIN; k++) begin
            s += hist[(t - DEPTH + k) & 1023] - b;
        end
        return s;
    endfunction

    task automatic tick();
        bit pop;
        bit pushed;
        int s;
        // checks on outputs settled after the previous edge
        check(out_valid == (mcount > 0), "R5 R6 out_valid", int'(out_valid), int'(mcount > 0));
        if (out_valid && mcount > 0) begin
            check($signed(out_sum) == eq[head], eq_tag[head], $signed(out_sum), eq[head]);
        end
        check(ovf == movf, "R9 ovf", int'(ovf), int'(movf));
        pop = drv_ready && (mcount > 0);
        if (auto_gen) drv_s = gen_sample();
        adc_in    = SW'(drv_s);
        trig      = drv_trig;
        cfg_we    = drv_we;
        cfg_thr   = AW'(drv_thr);
        out_ready = drv_ready;
        hist[e & 1023] = drv_s;
        // model of edge e
        if (e >= next_free) begin
            if (drv_we) mthr = drv_thr;
            if (drv_trig && e >= DEPTH + 2) begin
                s = window_sum(e);
                next_free = e + WIN + 2;
                if (s > mthr) begin
                    pend      = 1;
                    pend_edge = e + WIN + 1;
                    pend_val  = s;
                    pend_tag  = cur_tag;
                end
            end
        end
        pushed = 0;
        if (pend && pend_edge == e) begin
            pend = 0;
            if (mcount == FD) begin
                movf = 1;
            end else begin
                eq[tail & 255]     = pend_val;
                eq_tag[tail & 255] = pend_tag;
                tail++;
                pushed = 1;
            end
        end
        if (pop) head++;
        mcount = mcount + int'(pushed) - int'(pop);
        drv_trig = 0;
        drv_we   = 0;
        @(posedge clk);
        e++;
        @(negedge clk);
    endtask

    task automatic set_thr(input int v);
        drv_we  = 1;
        drv_thr = v;
        tick();
    endtask

    task automatic dir_case(input int bval, input int wval, input string tg);
        auto_gen = 0;
        cur_tag  = tg;
        drv_s    = bval;
        repeat (300) tick();
        drv_s = wval;
        repeat (DEPTH) tick();
        drv_trig = 1;
        tick();
        repeat (50) tick();
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(ovf == 1'b0, "R1 ovf", int'(ovf), 0);
        drv_ready = 1;
        auto_gen = 1;
        repeat (DEPTH + 10) tick();

        // R1: threshold resets to 0, so a zero sum is dropped, then threshold -1 stores it (R4)
        dir_case(500, 500, "R4 zero sum at reset threshold");
        set_thr(-1);
        dir_case(500, 500, "R4 zero sum above -1");
        // R4 equal threshold dropped, one below stored
        set_thr(200);
        dir_case(200, 205, "R4 equal threshold");
        set_thr(199);
        dir_case(200, 205, "R4 sum 200 over 199");
        // R3 extremes and negative sums
        set_thr(40919);
        dir_case(0, 1023, "R3 max positive");
        set_thr(-40921);
        dir_case(1023, 0, "R3 max negative");
        set_thr(-30000);
        dir_case(800, 100, "R3 negative sum");

        // R7 threshold write during a window is ignored
        set_thr(-50000);
        auto_gen = 1;
        cur_tag  = "R7 busy write";
        repeat (300) tick();
        drv_trig = 1;
        tick();
        repeat (5) tick();
        set_thr(60000);
        repeat (50) tick();
        dir_case(500, 500, "R7 old threshold kept");

        // R2 and R6 random stimulus with frequent triggers
        auto_gen = 1;
        cur_tag  = "R2 R6 random window";
        for (int i = 0; i < 4000; i++) begin
            if (i % 500 == 0) ped = $urandom_range(20, 700);
            drv_trig  = ($urandom_range(0, 9) == 0);
            drv_ready = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 39) == 0) begin
                drv_we  = 1;
                drv_thr = $urandom_range(0, 5000) - 2000;
            end
            tick();
        end
        drv_ready = 1;
        repeat (60) tick();

        // R8 and R9: queue fills with out_ready low, fifth result overflows
        set_thr(-50000);
        drv_ready = 0;
        cur_tag   = "R8 queue order";
        for (int i = 0; i < 5; i++) begin
            drv_trig = 1;
            tick();
            repeat (49) tick();
        end
        repeat (20) tick();
        check(ovf == 1'b1, "R9 overflow raised", int'(ovf), 1);
        drv_ready = 1;
        repeat (20) tick();
        check(ovf == 1'b1, "R9 overflow sticky", int'(ovf), 1);
        check(head == tail && !pend, "R6 all expected results seen", tail - head, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R6 actual=%0d expected=%0d", e, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule